// File: doc/BRIEF.md
# SPI Master Character Transmitter

This block sends 8-bit characters as an SPI master in mode 0. Software writes a character into a one-entry holding register. When the engine is free, and the receiver gate allows it, the character is copied into a shift register and sent most significant bit first on `mosi`, with `sclk` toggling only during the data bits.

The active-low select `ss_n` is framed around each character. It falls one bit period before the first data bit and rises one bit period after the last. It then stays high for a three-bit gap before the next character may start. A force command pins the select low across characters, and a release command frees it again. The `tx_ready` flag shows that the holding register can take a character. The `tx_empty` flag shows that nothing is waiting and the last character has fully left the shift register.

The timing base is a half-bit tick. It fires every `baud_div+1` clock cycles, so one bit period is `2*(baud_div+1)` cycles. The engine is a five-state machine:
- **IDLE**: waiting for a character.
- **SETUP**: select low, one bit period.
- **SHIFT**: eight bits, each with `sclk` low for the first half and high for the second.
- **HOLD**: select low, one bit period.
- **GAP**: select released, three bit periods.

The transitions are:
- IDLE→SETUP: a character is launchable.
- SETUP→SHIFT: after two half ticks.
- SHIFT→HOLD: after sixteen half ticks.
- HOLD→GAP: after two half ticks.
- GAP→SETUP: after six half ticks, when a character is launchable.
- GAP→IDLE: after six half ticks, when no character is launchable.

A character is launchable when the transmitter is enabled, the holding register is full, and either `wait_rd` is 0 or `rx_ready` is 0.

Top module: `spi_char_tx`

## Requirements
- R1: After reset `ss_n` is 1, `sclk` is 0 and `mosi` is 0.
- R2: While `tx_enable` is 0, `tx_ready` and `tx_empty` are 0, and a write is ignored: no character is sent, even after enabling.
- R3: A write while `tx_ready` is 1 is captured at that clock edge, and `tx_ready` reads 0 one cycle later. With the engine in IDLE, the character is loaded on the next edge: `ss_n` falls and `tx_ready` returns to 1.
- R4: Data is sent MSB first. `mosi` changes only when `sclk` falls and stays stable while `sclk` is high. There are exactly 8 rising `sclk` edges per character, and `sclk` idles at 0.
- R5: The first `sclk` rising edge comes `3*(baud_div+1)` cycles after `ss_n` falls, and `sclk` never goes high while `ss_n` is high.
- R6: `ss_n` rises `2*(baud_div+1)` cycles after the last falling `sclk` edge of a character, unless the select is forced.
- R7: When the next character is already held, `ss_n` stays high for exactly `6*(baud_div+1)` cycles between characters.
- R8: A write while `tx_ready` is 0 is ignored, and the character is lost.
- R9: With `wait_rd` at 1 and `rx_ready` at 1, no character is launched. The held character starts on the edge after `rx_ready` drops. With `wait_rd` at 0, `rx_ready` has no effect.
- R10: A `force_cs` pulse drives `ss_n` low from the next cycle and keeps it low across characters and gaps. Only `release_cs` returns it high, one cycle later and only outside a frame. `release_cs` wins if both strobes are given together.
- R11: `tx_empty` is 1 only when the transmitter is enabled, the holding register is empty and the engine is in IDLE or GAP. `tx_empty` therefore implies `tx_ready`.
- R12: The `sclk` high phase lasts `baud_div+1` cycles for any divider value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_enable | input | 1 | Transmitter enable |
| baud_div | input | DIV_W | Half-bit period minus one, in clock cycles |
| wait_rd | input | 1 | Hold launch while received data is unread |
| rx_ready | input | 1 | Receiver holds unread data |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Character to send |
| force_cs | input | 1 | Command: pin select low |
| release_cs | input | 1 | Command: free select |
| tx_ready | output | 1 | Holding register empty and writable |
| tx_empty | output | 1 | All written characters fully sent |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| ss_n | output | 1 | Active-low slave select |

## Verification
A write driven at a falling clock edge is captured at the next rising edge. The following falling edge shows `tx_ready` low, and the one after shows `ss_n` low with `tx_ready` high again. The bench samples those exact edges. The framing delays (3, 2 and 6 half-bit periods, and a 1 half-bit `sclk` high phase) are measured by a monitor that timestamps every `ss_n` and `sclk` transition at falling clock edges. Each measured delay is compared with the exact cycle count computed from `baud_div`. Results such as captured bytes or the absence of a launch are read only after a wait longer than one full character, so that a late or extra character would show up.

// File: rtl/spi_tx_pkg.sv
package spi_tx_pkg;
    typedef enum logic [2:0] {
        TX_IDLE,
        TX_SETUP,
        TX_SHIFT,
        TX_HOLD,
        TX_GAP
    } tx_state_e;

    // framing lengths in bit periods
    localparam int SETUP_BITS = 1;
    localparam int HOLD_BITS  = 1;
    localparam int GAP_BITS   = 3;
endpackage

// File: rtl/spi_tx_baud.sv
module spi_tx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/spi_tx_hold.sv
module spi_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              ready
);
    assign ready = enable && !full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else begin
            if (take)
                full <= 1'b0;
            if (wr_en && ready) begin
                full <= 1'b1;
                data <= wr_data;
            end
        end
    end
endmodule

// File: rtl/spi_tx_engine.sv
module spi_tx_engine
    import spi_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              can_start,
    input  logic [DATA_W-1:0] load_data,
    output logic              load,
    output logic              run,
    output logic              frame,
    output logic              quiet,
    output logic              sclk,
    output logic              mosi
);
    localparam int SETUP_H = 2 * SETUP_BITS;
    localparam int SHIFT_H = 2 * DATA_W;
    localparam int HOLD_H  = 2 * HOLD_BITS;
    localparam int GAP_H   = 2 * GAP_BITS;
    localparam int HC_W    = $clog2(SHIFT_H + GAP_H + SETUP_H + HOLD_H);

    tx_state_e         state_q, state_d;
    logic [HC_W-1:0]   hcnt_q;
    logic [DATA_W-1:0] shreg_q;
    logic              gap_end;

    assign gap_end = (state_q == TX_GAP) && tick && (hcnt_q == HC_W'(GAP_H - 1));
    assign load    = ((state_q == TX_IDLE) && can_start) || (gap_end && can_start);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (can_start) state_d = TX_SETUP;
            TX_SETUP: if (tick && hcnt_q == HC_W'(SETUP_H - 1)) state_d = TX_SHIFT;
            TX_SHIFT: if (tick && hcnt_q == HC_W'(SHIFT_H - 1)) state_d = TX_HOLD;
            TX_HOLD:  if (tick && hcnt_q == HC_W'(HOLD_H - 1))  state_d = TX_GAP;
            TX_GAP:   if (gap_end) state_d = can_start ? TX_SETUP : TX_IDLE;
            default:  state_d = TX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= TX_IDLE;
        else
            state_q <= state_d;
    end

    // half-tick counter and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt_q  <= '0;
            shreg_q <= '0;
        end else begin
            if (state_d != state_q)
                hcnt_q <= '0;
            else if (tick)
                hcnt_q <= hcnt_q + 1'b1;

            if (load)
                shreg_q <= load_data;
            else if (state_q == TX_SHIFT && tick && hcnt_q[0])
                shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
        end
    end

    // outputs
    always_comb begin
        run   = (state_q != TX_IDLE);
        frame = (state_q == TX_SETUP) || (state_q == TX_SHIFT) || (state_q == TX_HOLD);
        quiet = (state_q == TX_IDLE) || (state_q == TX_GAP);
        sclk  = (state_q == TX_SHIFT) && hcnt_q[0];
        mosi  = ((state_q == TX_SETUP) || (state_q == TX_SHIFT)) ? shreg_q[DATA_W-1] : 1'b0;
    end
endmodule

// File: rtl/spi_char_tx.sv
module spi_char_tx #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_enable,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              wait_rd,
    input  logic              rx_ready,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              force_cs,
    input  logic              release_cs,
    output logic              tx_ready,
    output logic              tx_empty,
    output logic              sclk,
    output logic              mosi,
    output logic              ss_n
);
    logic              tick_w, run_w, load_w, frame_w, quiet_w;
    logic              hold_full_w, can_start_w;
    logic [DATA_W-1:0] hold_data_w;
    logic              sel_forced_q;

    assign can_start_w = tx_enable && hold_full_w && (!wait_rd || !rx_ready);

    spi_tx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_w),
        .div   (baud_div),
        .tick  (tick_w)
    );

    spi_tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (tx_enable),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (load_w),
        .full    (hold_full_w),
        .data    (hold_data_w),
        .ready   (tx_ready)
    );

    spi_tx_engine #(.DATA_W(DATA_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_w),
        .can_start (can_start_w),
        .load_data (hold_data_w),
        .load      (load_w),
        .run       (run_w),
        .frame     (frame_w),
        .quiet     (quiet_w),
        .sclk      (sclk),
        .mosi      (mosi)
    );

    // select override: release has priority
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sel_forced_q <= 1'b0;
        else if (release_cs)
            sel_forced_q <= 1'b0;
        else if (force_cs)
            sel_forced_q <= 1'b1;
    end

    assign ss_n     = !(sel_forced_q || frame_w);
    assign tx_empty = tx_enable && !hold_full_w && quiet_w;
endmodule

// File: rtl/spi_char_tx_chk.sv
module spi_char_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_enable,
    input logic wait_rd,
    input logic rx_ready,
    input logic force_cs,
    input logic release_cs,
    input logic tx_ready,
    input logic tx_empty,
    input logic sclk,
    input logic mosi,
    input logic ss_n,
    input logic sel_forced,
    input logic eng_load
);
    assert_sclk_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !ss_n);

    assert_mosi_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    assert_flags_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |-> (!tx_ready && !tx_empty));

    assert_empty_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_ready);

    assert_forced_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sel_forced |-> !ss_n);

    assert_force_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (force_cs && !release_cs) |=> !ss_n);

    assert_wait_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eng_load |-> !(wait_rd && rx_ready));

    assert_load_frees_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_load && tx_enable) |=> (tx_ready || !tx_enable));
endmodule

bind spi_char_tx spi_char_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_enable  (tx_enable),
    .wait_rd    (wait_rd),
    .rx_ready   (rx_ready),
    .force_cs   (force_cs),
    .release_cs (release_cs),
    .tx_ready   (tx_ready),
    .tx_empty   (tx_empty),
    .sclk       (sclk),
    .mosi       (mosi),
    .ss_n       (ss_n),
    .sel_forced (sel_forced_q),
    .eng_load   (load_w)
);

// File: tb/spi_char_tx_test.sv
module spi_char_tx_test;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 8;
    localparam int DIV_W  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_enable = 1'b0;
    logic [DIV_W-1:0] baud_div = '0;
    logic wait_rd = 1'b0, rx_ready = 1'b0;
    logic wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic force_cs = 1'b0, release_cs = 1'b0;
    logic tx_ready, tx_empty, sclk, mosi, ss_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_char_tx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) uut (
        .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .baud_div(baud_div),
        .wait_rd(wait_rd), .rx_ready(rx_ready), .wr_en(wr_en), .wr_data(wr_data),
        .force_cs(force_cs), .release_cs(release_cs), .tx_ready(tx_ready),
        .tx_empty(tx_empty), .sclk(sclk), .mosi(mosi), .ss_n(ss_n)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    // monitor state, written only by the monitor
    int cyc = 0, nbytes = 0, nfalls = 0, nrises = 0, bad_sclk = 0;
    int t_ssfall = 0, t_ssrise = 0, t_first_rise = 0, t_last_fall = 0;
    int setup_d = 0, hold_d = 0, high_d = 0, last_gap = 0;
    int bitcnt = 0;
    logic [DATA_W-1:0] cap = '0;
    logic [DATA_W-1:0] rxbuf [0:63];
    logic p_ss = 1'b1, p_sclk = 1'b0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (sclk && ss_n) bad_sclk <= bad_sclk + 1;
        if (p_ss && !ss_n) begin
            nfalls <= nfalls + 1;
            t_ssfall <= cyc;
            if (nrises > 0) last_gap <= cyc - t_ssrise;
        end
        if (!p_ss && ss_n) begin
            nrises <= nrises + 1;
            t_ssrise <= cyc;
            hold_d <= cyc - t_last_fall;
        end
        if (!p_sclk && sclk) begin
            cap <= {cap[DATA_W-2:0], mosi};
            bitcnt <= bitcnt + 1;
            if (bitcnt == 0) begin
                t_first_rise <= cyc;
                setup_d <= cyc - t_ssfall;
            end
        end
        if (p_sclk && !sclk) begin
            t_last_fall <= cyc;
            if (bitcnt == 1) high_d <= cyc - t_first_rise;
            if (bitcnt == DATA_W) begin
                rxbuf[nbytes[5:0]] <= cap;
                nbytes <= nbytes + 1;
                bitcnt <= 0;
            end
        end
        p_ss <= ss_n;
        p_sclk <= sclk;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_char(input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_bytes(input int n, input int dv);
        while (nbytes < n) begin
            @(negedge clk);
            #1;
        end
        repeat (2*(dv+1) + 3) @(negedge clk);
        #1;
    endtask

    task automatic settle(input int dv);
        repeat (6*(dv+1) + 4) @(negedge clk);
        #1;
    endtask

    task automatic t_reset_and_disable();
        @(negedge clk);
        chk("R1", "ss_n after reset", int'(ss_n), 1);
        chk("R1", "sclk after reset", int'(sclk), 0);
        chk("R1", "mosi after reset", int'(mosi), 0);
        chk("R2", "tx_ready disabled", int'(tx_ready), 0);
        chk("R2", "tx_empty disabled", int'(tx_empty), 0);
        write_char(8'h3C);
        repeat (20) @(negedge clk);
        tx_enable = 1'b1;
        repeat (40) @(negedge clk);
        #1;
        chk("R2", "select falls after ignored write", nfalls, 0);
        chk("R2", "tx_ready after enable", int'(tx_ready), 1);
        chk("R2", "tx_empty after enable", int'(tx_empty), 1);
    endtask

    task automatic t_single(input logic [DATA_W-1:0] d, input int dv);
        int n0;
        baud_div = DIV_W'(dv);
        n0 = nbytes;
        write_char(d);
        chk("R3", "tx_ready one cycle after write", int'(tx_ready), 0);
        chk("R3", "ss_n one cycle after write", int'(ss_n), 1);
        @(negedge clk);
        chk("R3", "ss_n two cycles after write", int'(ss_n), 0);
        chk("R3", "tx_ready after load", int'(tx_ready), 1);
        chk("R11", "tx_empty during frame", int'(tx_empty), 0);
        wait_bytes(n0 + 1, dv);
        chk("R4", "byte MSB first", int'(rxbuf[n0[5:0]]), int'(d));
        chk("R5", "select to first sclk rise", setup_d, 3*(dv+1));
        chk("R6", "last sclk fall to select rise", hold_d, 2*(dv+1));
        chk("R12", "sclk high phase", high_d, dv+1);
        chk("R11", "tx_empty after frame", int'(tx_empty), 1);
        chk("R4", "sclk idle", int'(sclk), 0);
        settle(dv);
    endtask

    task automatic t_back_to_back();
        int n0;
        baud_div = DIV_W'(1);
        n0 = nbytes;
        write_char(8'h81);
        @(negedge clk);
        write_char(8'h7E);
        chk("R8", "tx_ready with holding full", int'(tx_ready), 0);
        write_char(8'hFF);
        wait_bytes(n0 + 2, 1);
        repeat (60) @(negedge clk);
        #1;
        chk("R7", "gap between characters", last_gap, 6*2);
        chk("R4", "first byte", int'(rxbuf[n0[5:0]]), 8'h81);
        chk("R4", "second byte", int'(rxbuf[6'(n0+1)]), 8'h7E);
        chk("R8", "write while not ready lost", nbytes - n0, 2);
        chk("R11", "tx_empty when drained", int'(tx_empty), 1);
    endtask

    task automatic t_wait_read();
        int n0, f0;
        baud_div = '0;
        wait_rd = 1'b1;
        rx_ready = 1'b1;
        f0 = nfalls;
        n0 = nbytes;
        write_char(8'hC3);
        repeat (40) @(negedge clk);
        #1;
        chk("R9", "no launch while unread", nfalls - f0, 0);
        chk("R9", "character kept while gated", int'(tx_ready), 0);
        rx_ready = 1'b0;
        @(negedge clk);
        chk("R9", "launch after read", int'(ss_n), 0);
        wait_bytes(n0 + 1, 0);
        chk("R9", "gated byte", int'(rxbuf[n0[5:0]]), 8'hC3);
        settle(0);
        wait_rd = 1'b0;
        rx_ready = 1'b1;
        write_char(8'h5A);
        @(negedge clk);
        chk("R9", "gate off ignores rx_ready", int'(ss_n), 0);
        wait_bytes(n0 + 2, 0);
        chk("R9", "ungated byte", int'(rxbuf[6'(n0+1)]), 8'h5A);
        rx_ready = 1'b0;
        settle(0);
    endtask

    task automatic t_force();
        int n0, r0;
        baud_div = DIV_W'(2);
        @(negedge clk);
        force_cs = 1'b1;
        @(negedge clk);
        force_cs = 1'b0;
        chk("R10", "forced select low", int'(ss_n), 0);
        r0 = nrises;
        n0 = nbytes;
        write_char(8'h96);
        @(negedge clk);
        write_char(8'h1E);
        wait_bytes(n0 + 2, 2);
        settle(2);
        chk("R10", "no release across characters", nrises - r0, 0);
        chk("R10", "select still low", int'(ss_n), 0);
        chk("R10", "forced bytes", int'(rxbuf[6'(n0+1)]), 8'h1E);
        release_cs = 1'b1;
        @(negedge clk);
        release_cs = 1'b0;
        chk("R10", "select after release", int'(ss_n), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_and_disable();
        t_single(8'hA5, 1);
        t_single(8'h01, 0);
        t_single(8'hB4, 3);
        t_back_to_back();
        t_wait_read();
        t_force();
        chk("R5", "sclk pulses outside select", bad_sclk, 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule